// File: doc/BRIEF.md
# Byte-Serialized Result Readout

This block gives an 8-bit host access to a bank of four 16-bit converter results. The conversion side loads a whole 16-bit word into one chosen result slot. The host sees each slot at two byte addresses. The even address returns the upper half. The odd address returns the lower half.

A read of the upper half sends the live upper byte to the bus. In the same cycle it copies that slot's lower byte into one hold byte that all slots share. Every read of a lower-half address returns that hold byte and never the live lower byte. So reading upper then lower gives a coherent 16-bit value, even if the conversion side rewrites the slot between the two reads. Software reads the upper half first. An upper-only read is always valid. A lower-only read returns whatever the hold byte last captured.

Top module: `res_readout_top`

## Requirements
- R1: After reset, all four result slots and the hold byte are zero, so a read at any of the eight byte addresses returns 0x00.
- R2: When `cnv_we` is high at a clock edge, slot `cnv_sel` takes the full `cnv_data` word at that edge. The other slots keep their values.
- R3: A host read (`host_rd`=1, `host_wr`=0) at even address 2·i returns bits 15:8 of slot i on `host_rdata` in the same cycle.
- R4: A read at even address 2·i loads bits 7:0 of slot i, as they stand in that cycle, into the shared hold byte at the closing clock edge.
- R5: A host read at odd address 2·i+1 returns the hold byte, not bits 7:0 of slot i.
- R6: A read at an odd address leaves the hold byte unchanged, so repeated lower-half reads return the same byte.
- R7: When slot i is rewritten after its upper-half read, the following lower-half read still returns the lower byte of the earlier value.
- R8: When the conversion side writes slot i in the same cycle that the host reads slot i's upper half, the read returns the old upper byte and the hold byte takes the old lower byte. The new word is visible from the next cycle.
- R9: A cycle with `host_wr` high is not a read. It changes no slot and not the hold byte, and `host_rdata` is 0x00.
- R10: `host_rdata` is 0x00 in every cycle without a valid host read.
- R11: With 0xAA40 stored in a slot, an upper-half read returns 0xAA and the following lower-half read returns 0x40.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cnv_we | input | 1 | Conversion-side load strobe |
| cnv_sel | input | 2 | Slot chosen for the load |
| cnv_data | input | 16 | Result word to load |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe (ignored; cancels a read) |
| host_addr | input | 3 | Byte address: slot·2 for the upper half, slot·2+1 for the lower half |
| host_rdata | output | 8 | Read data, valid in the cycle of the read |

## Verification
The collision that matters is a conversion load and a host upper-half read hitting the same slot in the same cycle. Both then act on one register, and the read and the capture into the hold byte must see the pre-load word. The bench forces this on purpose with a load and a read on one slot in one cycle, and also lets it happen often in a random phase. A behavioural model updates its hold byte from its pre-load slot value and only then applies the load. The model is compared with `host_rdata` every cycle, and a later lower-half read shows which lower byte was captured.

// File: rtl/rr_pkg.sv
package rr_pkg;
  localparam int unsigned RR_BYTE_W = 8;
  localparam int unsigned RR_WORD_W = 2 * RR_BYTE_W;

  typedef logic [RR_BYTE_W-1:0] byte_t;
  typedef logic [RR_WORD_W-1:0] word_t;

  typedef enum logic {HALF_UPPER = 1'b0, HALF_LOWER = 1'b1} half_e;

  function automatic byte_t upper_half(input word_t w);
    return w[RR_WORD_W-1:RR_BYTE_W];
  endfunction

  function automatic byte_t lower_half(input word_t w);
    return w[RR_BYTE_W-1:0];
  endfunction

  function automatic half_e half_of(input logic addr_lsb);
    return addr_lsb ? HALF_LOWER : HALF_UPPER;
  endfunction
endpackage

// File: rtl/rr_slot_bank.sv
module rr_slot_bank
  import rr_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 4,
  localparam int unsigned SEL_W = $clog2(NUM_SLOTS)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            ld_en,
  input  logic [SEL_W-1:0]                ld_sel,
  input  word_t                           ld_word,
  input  logic [SEL_W-1:0]                rd_sel,
  output word_t                           rd_word,
  output logic [NUM_SLOTS*RR_WORD_W-1:0]  bank_flat
);
  word_t slot_q [NUM_SLOTS];

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    logic hit;
    assign hit = ld_en && (ld_sel == SEL_W'(i));
    always_ff @(posedge clk) begin
      if (!rst_n)   slot_q[i] <= '0;
      else if (hit) slot_q[i] <= ld_word;
    end
    assign bank_flat[i*RR_WORD_W +: RR_WORD_W] = slot_q[i];
  end

  assign rd_word = slot_q[rd_sel];
endmodule

// File: rtl/rr_hold_byte.sv
module rr_hold_byte
  import rr_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  capture,
  input  byte_t din,
  output byte_t q
);
  always_ff @(posedge clk) begin
    if (!rst_n)        q <= '0;
    else if (capture)  q <= din;
  end
endmodule

// File: rtl/rr_read_mux.sv
module rr_read_mux
  import rr_pkg::*;
(
  input  logic  rd_evt,
  input  half_e half,
  input  word_t live_word,
  input  byte_t hold_q,
  output byte_t rdata
);
  always_comb begin
    rdata = '0;
    if (rd_evt) begin
      unique case (half)
        HALF_UPPER: rdata = upper_half(live_word);
        HALF_LOWER: rdata = hold_q;
        default:    rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/res_readout_top.sv
module res_readout_top
  import rr_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 4,
  localparam int unsigned SEL_W  = $clog2(NUM_SLOTS),
  localparam int unsigned ADDR_W = SEL_W + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cnv_we,
  input  logic [SEL_W-1:0]     cnv_sel,
  input  logic [RR_WORD_W-1:0] cnv_data,
  input  logic                 host_rd,
  input  logic                 host_wr,
  input  logic [ADDR_W-1:0]    host_addr,
  output logic [RR_BYTE_W-1:0] host_rdata
);
  // decoded host events, named for the checker
  logic                          rd_evt;
  logic                          hi_rd_evt;
  logic                          lo_rd_evt;
  half_e                         half;
  logic [SEL_W-1:0]              rd_sel;
  word_t                         sel_word;
  byte_t                         hold_q;
  logic [NUM_SLOTS*RR_WORD_W-1:0] bank_flat;

  assign rd_evt    = host_rd && !host_wr;
  assign half      = half_of(host_addr[0]);
  assign rd_sel    = host_addr[ADDR_W-1:1];
  assign hi_rd_evt = rd_evt && (half == HALF_UPPER);
  assign lo_rd_evt = rd_evt && (half == HALF_LOWER);

  rr_slot_bank #(.NUM_SLOTS(NUM_SLOTS)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld_en    (cnv_we),
    .ld_sel   (cnv_sel),
    .ld_word  (cnv_data),
    .rd_sel   (rd_sel),
    .rd_word  (sel_word),
    .bank_flat(bank_flat)
  );

  rr_hold_byte u_hold (
    .clk    (clk),
    .rst_n  (rst_n),
    .capture(hi_rd_evt),
    .din    (lower_half(sel_word)),
    .q      (hold_q)
  );

  rr_read_mux u_mux (
    .rd_evt   (rd_evt),
    .half     (half),
    .live_word(sel_word),
    .hold_q   (hold_q),
    .rdata    (host_rdata)
  );
endmodule

// File: rtl/rr_checker.sv
module rr_checker
  import rr_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 4,
  localparam int unsigned SEL_W = $clog2(NUM_SLOTS)
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           cnv_we,
  input logic [SEL_W-1:0]               cnv_sel,
  input logic [RR_WORD_W-1:0]           cnv_data,
  input logic                           host_rd,
  input logic                           host_wr,
  input logic [RR_BYTE_W-1:0]           host_rdata,
  input logic                           hi_rd_evt,
  input logic                           lo_rd_evt,
  input logic [RR_WORD_W-1:0]           sel_word,
  input logic [RR_BYTE_W-1:0]           hold_q,
  input logic [NUM_SLOTS*RR_WORD_W-1:0] bank_flat
);
  logic             prev_we;
  logic [SEL_W-1:0] prev_sel;
  word_t            prev_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_we   <= 1'b0;
      prev_sel  <= '0;
      prev_data <= '0;
    end else begin
      prev_we   <= cnv_we;
      prev_sel  <= cnv_sel;
      prev_data <= cnv_data;
    end
  end

  a_r2_load_lands: assert property (@(posedge clk) disable iff (!rst_n)
    prev_we |-> bank_flat[prev_sel*RR_WORD_W +: RR_WORD_W] == prev_data);

  a_r3_upper_live: assert property (@(posedge clk) disable iff (!rst_n)
    hi_rd_evt |-> host_rdata == sel_word[RR_WORD_W-1:RR_BYTE_W]);

  a_r4_hold_capture: assert property (@(posedge clk) disable iff (!rst_n)
    hi_rd_evt |=> hold_q == $past(sel_word[RR_BYTE_W-1:0]));

  a_r5_lower_from_hold: assert property (@(posedge clk) disable iff (!rst_n)
    lo_rd_evt |-> host_rdata == hold_q);

  a_r6_hold_steady: assert property (@(posedge clk) disable iff (!rst_n)
    !hi_rd_evt |=> $stable(hold_q));

  a_r9_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && !cnv_we) |=> $stable(bank_flat) && $stable(hold_q));

  a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_rd || host_wr) |-> host_rdata == '0);
endmodule

bind res_readout_top rr_checker #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cnv_we    (cnv_we),
  .cnv_sel   (cnv_sel),
  .cnv_data  (cnv_data),
  .host_rd   (host_rd),
  .host_wr   (host_wr),
  .host_rdata(host_rdata),
  .hi_rd_evt (hi_rd_evt),
  .lo_rd_evt (lo_rd_evt),
  .sel_word  (sel_word),
  .hold_q    (hold_q),
  .bank_flat (bank_flat)
);

// File: tb/res_readout_top_tb.sv
module res_readout_top_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cnv_we;
  logic [1:0]  cnv_sel;
  logic [15:0] cnv_data;
  logic        host_rd;
  logic        host_wr;
  logic [2:0]  host_addr;
  logic [7:0]  host_rdata;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  // behavioural reference
  logic [15:0] mdl [4];
  logic [7:0]  mdl_hold;

  always #4 clk = ~clk;

  res_readout_top u_dut (
    .clk(clk), .rst_n(rst_n), .cnv_we(cnv_we), .cnv_sel(cnv_sel),
    .cnv_data(cnv_data), .host_rd(host_rd), .host_wr(host_wr),
    .host_addr(host_addr), .host_rdata(host_rdata)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: host_rdata actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // one cycle: drive after the falling edge, compare before the rising edge
  task automatic step(input logic rd, input logic wr, input logic [2:0] addr,
                      input logic we, input logic [1:0] sel, input logic [15:0] data,
                      input string tag);
    logic [7:0] exp;
    int idx;
    @(negedge clk);
    host_rd = rd; host_wr = wr; host_addr = addr;
    cnv_we = we; cnv_sel = sel; cnv_data = data;
    #1;
    idx = int'(addr) / 2;
    exp = 8'h00;
    if (rd && !wr) exp = (addr % 2 == 0) ? mdl[idx][15:8] : mdl_hold;
    check(tag, host_rdata, exp);
    if (rd && !wr && (addr % 2 == 0)) mdl_hold = mdl[idx][7:0];
    if (we) mdl[sel] = data;
  endtask

  task automatic rd_hi(input int s, input string tag);
    step(1'b1, 1'b0, 3'(2*s), 1'b0, 2'd0, 16'h0, tag);
  endtask

  task automatic rd_lo(input int s, input string tag);
    step(1'b1, 1'b0, 3'(2*s+1), 1'b0, 2'd0, 16'h0, tag);
  endtask

  task automatic load(input int s, input logic [15:0] d, input string tag);
    step(1'b0, 1'b0, 3'd0, 1'b1, 2'(s), d, tag);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; host_rd = 0; host_wr = 0; host_addr = 0;
    cnv_we = 0; cnv_sel = 0; cnv_data = 0;
    for (int i = 0; i < 4; i++) mdl[i] = 16'h0;
    mdl_hold = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: reset state at all byte addresses
    for (int a = 0; a < 8; a++) step(1'b1, 1'b0, 3'(a), 1'b0, 2'd0, 16'h0, "R1");

    // R11: worked example
    load(0, 16'hAA40, "R10");
    rd_hi(0, "R11");
    rd_lo(0, "R11");

    // R2, R3, R4, R5: distinct words in every slot
    load(1, 16'h1234, "R2");
    load(2, 16'hBEEF, "R2");
    load(3, 16'h5AC3, "R2");
    for (int s = 0; s < 4; s++) begin
      rd_hi(s, "R3");
      rd_lo(s, "R4");
    end

    // R5: lower-only read returns the hold byte, not the live byte
    rd_hi(3, "R3");
    rd_lo(2, "R5");
    rd_lo(1, "R5");

    // R6: repeated lower reads
    rd_hi(2, "R3");
    for (int k = 0; k < 3; k++) rd_lo(2, "R6");
    rd_lo(0, "R6");

    // R7: rewrite between upper and lower reads
    rd_hi(1, "R3");
    load(1, 16'h9977, "R7");
    rd_lo(1, "R7");
    rd_hi(1, "R7");
    rd_lo(1, "R7");

    // R8: load and upper read of the same slot in one cycle
    step(1'b1, 1'b0, 3'd4, 1'b1, 2'd2, 16'hC0DE, "R8");
    rd_lo(2, "R8");
    rd_hi(2, "R8");
    rd_lo(2, "R8");

    // R9: host write strobes, with and without read strobe
    for (int a = 0; a < 8; a++) step(1'b0, 1'b1, 3'(a), 1'b0, 2'd0, 16'h0, "R9");
    step(1'b1, 1'b1, 3'd6, 1'b0, 2'd0, 16'h0, "R9");
    rd_lo(3, "R9");
    for (int s = 0; s < 4; s++) rd_hi(s, "R9");

    // R10: idle cycles
    step(1'b0, 1'b0, 3'd2, 1'b0, 2'd0, 16'h0, "R10");

    // random mix, model compared every cycle
    for (int n = 0; n < 600; n++) begin
      logic       r, w, we;
      logic [2:0] a;
      logic [1:0] sl;
      logic [15:0] d;
      string tg;
      r  = ($urandom % 4) != 0;
      w  = ($urandom % 8) == 0;
      we = ($urandom % 2) == 1;
      a  = 3'($urandom);
      sl = 2'($urandom);
      d  = 16'($urandom);
      if (we && ($urandom % 3 == 0)) sl = a[2:1];
      if (!r || w)          tg = w ? "R9" : "R10";
      else if (a[0] == 1'b0) tg = (we && sl == a[2:1]) ? "R8" : "R3";
      else                   tg = "R5";
      step(r, w, a, we, sl, d, tg);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule